// File: doc/BRIEF.md
# PDM Microphone Capture Front End

This block sits between a one-bit pulse-density-modulated microphone and a downstream decimation filter. It divides the fast system clock down to the microphone bit clock and drives that clock out to the microphone. It then reads the single data bit the microphone returns, one bit for every microphone clock period.

Each captured bit becomes one signed byte, carried on an AXI4-Stream master output. A one becomes +127 and a zero becomes -127, both written as full 8-bit two's complement values, so a signed filter input can take the stream as it is. The stream carries one word per microphone bit and never packs several bits into one word. It has no storage. A word offered while the sink is not ready is lost, and a sticky flag records that loss.

The divide ratio comes from two parameters: the system clock frequency and the wanted microphone clock frequency. The defaults give a 3.072 MHz microphone clock from 98.304 MHz.

Top module: `pdm_capture_top`

## Requirements
- R1: The microphone clock output repeats every DIV system clock cycles, where DIV = SYS_CLK_HZ / MIC_CLK_HZ (minimum 2).
- R2: In every period the microphone clock is high for DIV/2 system cycles, rounded down, which gives a 50% duty cycle when DIV is even.
- R3: A captured bit of 1 is output as tdata 8'h7F (+127) and a bit of 0 as 8'h81 (-127). Every bit of the byte is driven, so the sign reaches bit 7.
- R4: tvalid is high for exactly one system cycle per microphone clock period, which gives exactly one stream word per captured bit.
- R5: The data pin passes through a two-flop synchroniser and is sampled on the system cycle in which the microphone clock goes high. tvalid and the matching tdata appear on the following system cycle. A pin level held steady for the three system cycles before the rise is the level captured.
- R6: If tready is low in a cycle where tvalid is high, the overflow output goes high on the next cycle and stays high until reset. A low tready in a cycle without tvalid does not set it.
- R7: While reset is high, the microphone clock, tvalid and overflow are all low. The microphone clock rises in the first system cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pdm_data_i | input | 1 | One-bit data returned by the microphone |
| m_tready_i | input | 1 | Stream sink ready |
| pdm_clk_o | output | 1 | Bit clock driven to the microphone |
| m_tdata_o | output | 8 | Signed sample, +127 or -127 |
| m_tvalid_o | output | 1 | One-cycle pulse per captured bit |
| overflow_o | output | 1 | Sticky flag: a word was offered while the sink was not ready |

## Verification
The data pin is driven serially with every 8-bit value from 0 to 255, bit by bit, so the bit stream contains runs of every length up to eight as well as alternating patterns. This separates a correct per-bit capture from a capture that is one word late or early, inverted, or stale. For each word the bench also measures the interval between words, the number of high cycles of the microphone clock, and the delay from the clock rise to tvalid, which show up a wrong divide, a wrong duty cycle or a wrong sample point. The sink's ready signal is first dropped only between words and then dropped across a word, to separate a correct overflow condition from one that reacts to ready alone. Further words are then taken with ready high to show that the flag stays set, and a reset follows to show that it clears.

// File: rtl/pdm_capture_pkg.sv
package pdm_capture_pkg;

    localparam int unsigned SAMPLE_W = 8;

    typedef logic signed [SAMPLE_W-1:0] sample_t;

    localparam sample_t POS_FULL = sample_t'((1 << (SAMPLE_W - 1)) - 1);
    localparam sample_t NEG_FULL = -POS_FULL;

    function automatic sample_t bit_to_sample(input logic b);
        return b ? POS_FULL : NEG_FULL;
    endfunction

endpackage

// File: rtl/pdm_clock_gen.sv
module pdm_clock_gen #(
    parameter int unsigned DIV = 32
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic pdm_clk_o,
    output logic rise_o
);
    localparam int unsigned CNT_W   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int unsigned HIGH_N  = DIV / 2;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             clk;
        logic             rise;
    } gen_state_t;

    gen_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.cnt  = (s_q.cnt == LAST) ? '0 : s_q.cnt + 1'b1;
        s_d.clk  = (int'(s_d.cnt) < HIGH_N);
        s_d.rise = (s_d.cnt == '0);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q.cnt  <= LAST;
            s_q.clk  <= 1'b0;
            s_q.rise <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pdm_clk_o = s_q.clk;
    assign rise_o    = s_q.rise;

    // R5: the sample strobe coincides with a rising microphone clock
    a_r5_strobe_on_rise: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |-> (pdm_clk_o && !$past(pdm_clk_o)));
    a_r5_rise_has_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
        (pdm_clk_o && !$past(pdm_clk_o)) |-> rise_o);
    // R7: clock held low through reset
    a_r7_clk_low_in_reset: assert property (@(posedge clk_i)
        rst_i |=> !pdm_clk_o);
endmodule

// File: rtl/pdm_bit_sync.sv
module pdm_bit_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i) begin
        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pdm_stream_out.sv
module pdm_stream_out
    import pdm_capture_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    strobe_i,
    input  logic    bit_i,
    input  logic    tready_i,
    output sample_t tdata_o,
    output logic    tvalid_o,
    output logic    overflow_o
);
    typedef struct packed {
        sample_t data;
        logic    valid;
        logic    ovf;
    } out_state_t;

    out_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.valid = strobe_i;
        if (strobe_i) begin
            s_d.data = bit_to_sample(bit_i);
        end
        s_d.ovf = s_q.ovf | (s_q.valid & ~tready_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q.data  <= NEG_FULL;
            s_q.valid <= 1'b0;
            s_q.ovf   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tdata_o    = s_q.data;
    assign tvalid_o   = s_q.valid;
    assign overflow_o = s_q.ovf;

    // R3: only the two symmetric codes appear on a valid word
    a_r3_symmetric_code: assert property (@(posedge clk_i) disable iff (rst_i)
        tvalid_o |-> (tdata_o == POS_FULL || tdata_o == NEG_FULL));
    // R4: a word is offered for a single cycle
    a_r4_single_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
        tvalid_o |=> !tvalid_o);
    // R6: a refused word raises the flag, and the flag holds
    a_r6_set_on_refusal: assert property (@(posedge clk_i) disable iff (rst_i)
        (tvalid_o && !tready_i) |=> overflow_o);
    a_r6_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        overflow_o |=> overflow_o);
    a_r6_no_spurious: assert property (@(posedge clk_i) disable iff (rst_i)
        (!overflow_o && !tvalid_o) |=> !overflow_o);
    // R7: stream idle and flag clear after reset
    a_r7_idle_in_reset: assert property (@(posedge clk_i)
        rst_i |=> (!tvalid_o && !overflow_o));
endmodule

// File: rtl/pdm_capture_top.sv
module pdm_capture_top
    import pdm_capture_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ  = 98_304_000,
    parameter int unsigned MIC_CLK_HZ  = 3_072_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                pdm_data_i,
    input  logic                m_tready_i,
    output logic                pdm_clk_o,
    output logic [SAMPLE_W-1:0] m_tdata_o,
    output logic                m_tvalid_o,
    output logic                overflow_o
);
    localparam int unsigned DIV = SYS_CLK_HZ / MIC_CLK_HZ;

    initial begin
        assert (DIV >= 2) else $error("divide ratio below 2");
        assert (SYNC_STAGES >= 2) else $error("synchroniser too short");
    end

    logic    rise;
    logic    bit_sync;
    sample_t tdata;

    pdm_clock_gen #(.DIV(DIV)) i_clock_gen (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .pdm_clk_o (pdm_clk_o),
        .rise_o    (rise)
    );

    pdm_bit_sync #(.STAGES(SYNC_STAGES)) i_bit_sync (
        .clk_i (clk_i),
        .d_i   (pdm_data_i),
        .q_o   (bit_sync)
    );

    pdm_stream_out i_stream_out (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .strobe_i   (rise),
        .bit_i      (bit_sync),
        .tready_i   (m_tready_i),
        .tdata_o    (tdata),
        .tvalid_o   (m_tvalid_o),
        .overflow_o (overflow_o)
    );

    assign m_tdata_o = tdata;

    // R4: a word follows each clock rise by one cycle
    a_r4_word_per_rise: assert property (@(posedge clk_i) disable iff (rst_i)
        (pdm_clk_o && !$past(pdm_clk_o)) |=> m_tvalid_o);
endmodule

// File: tb/test_pdm_capture_top.sv
`timescale 1ns/1ps
module test_pdm_capture_top;
    localparam int DIV   = 6;
    localparam int WORDS = 2048;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pdm = 1'b0;
    logic       tready = 1'b1;
    logic       pdm_clk;
    logic [7:0] tdata;
    logic       tvalid;
    logic       ovf;

    int n_tests = 0;
    int n_fail  = 0;
    int interval, highs, age;
    logic prev_clk = 1'b0;
    bit done = 0;

    always #5 clk = ~clk;

    pdm_capture_top #(.SYS_CLK_HZ(18_432_000), .MIC_CLK_HZ(3_072_000)) i_pdm_capture_top (
        .clk_i      (clk),
        .rst_i      (rst),
        .pdm_data_i (pdm),
        .m_tready_i (tready),
        .pdm_clk_o  (pdm_clk),
        .m_tdata_o  (tdata),
        .m_tvalid_o (tvalid),
        .overflow_o (ovf)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic logic stream_bit(input int n);
        return logic'(((n / 8) >> (n % 8)) & 1);
    endfunction

    task automatic step();
        @(negedge clk);
        interval++;
        if (pdm_clk) highs++;
        if (pdm_clk && !prev_clk) age = 0; else age++;
        prev_clk = pdm_clk;
    endtask

    task automatic wait_tvalid();
        interval = 0;
        highs = 0;
        do step(); while (!tvalid && interval < 1000);
    endtask

    task automatic reset_checks(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            step();
            check(pdm_clk == 1'b0, "R7 clk low in reset", pdm_clk, 0);
            check(tvalid == 1'b0, "R7 tvalid low in reset", tvalid, 0);
            check(ovf == 1'b0, "R7 overflow clear in reset", ovf, 0);
        end
    endtask

    initial begin
        rst = 1'b1;
        pdm = stream_bit(0);
        reset_checks(6);
        rst = 1'b0;
        step();
        check(pdm_clk == 1'b1, "R7 first rise right after reset", pdm_clk, 1);
        for (int n = 0; n < WORDS; n++) begin
            wait_tvalid();
            check(tdata == (stream_bit(n) ? 8'h7F : 8'h81), "R3/R5 sample value",
                  tdata, stream_bit(n) ? 8'h7F : 8'h81);
            check(age == 1, "R5 tvalid one cycle after rise", age, 1);
            if (n > 0) begin
                check(interval == DIV, "R1/R4 word interval", interval, DIV);
                check(highs == DIV / 2, "R2 high cycles per period", highs, DIV / 2);
            end
            pdm = stream_bit(n + 1);
        end
        check(ovf == 1'b0, "R6 no overflow with ready high", ovf, 0);

        // ready low only between words
        step();
        tready = 1'b0;
        step();
        step();
        tready = 1'b1;
        wait_tvalid();
        step();
        check(ovf == 1'b0, "R6 ready low without tvalid ignored", ovf, 0);

        // ready low across a word
        tready = 1'b0;
        wait_tvalid();
        check(ovf == 1'b0, "R6 flag not yet set in word cycle", ovf, 0);
        step();
        check(ovf == 1'b1, "R6 flag set after refused word", ovf, 1);
        tready = 1'b1;
        for (int k = 0; k < 3; k++) wait_tvalid();
        step();
        check(ovf == 1'b1, "R6 flag sticky", ovf, 1);

        rst = 1'b1;
        step();
        reset_checks(4);
        rst = 1'b0;
        step();
        check(pdm_clk == 1'b1, "R7 rise after second reset", pdm_clk, 1);
        done = 1;
    end

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run completion)");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule